// File: doc/BRIEF.md
# GPIO Bank with Latched Interrupt Detection

This block is a bank of general-purpose pins reached through a small register bus. For each pin, software sets an output value and an output-enable bit, and it can read back the pin level after synchronization. Each pin also has its own event detector. Software selects edge or level sensing and the active polarity for each pin. Any detected event is recorded in a sticky status register. Software removes a status bit by writing a one to that bit of the clear register.

Level events are latched in status just like edge events, so a level interrupt also needs an explicit clear. A detector in level mode keeps setting its status bit for as long as its input stays active. A single interrupt line goes high when a status bit is set and the matching enable bit is also set. The bank has no native both-edge mode. Software gets the same effect by flipping a pin's polarity after each event. A polarity write resynchronizes the detector's history, so the flip itself never produces an event.

The bus is single-cycle. A write takes effect on the rising edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high, and is zero otherwise. Register map (3-bit address): 0 output data, 1 input data (read only), 2 status (read only), 3 clear (write only, reads 0), 4 interrupt enable, 5 mode (1 = edge, 0 = level), 6 polarity (1 = rising/high, 0 = falling/low), 7 output enable.

Top module: `gpio_bank`

## Requirements
- R1: After reset, `pin_out`, `pin_oe` and `irq_out` are 0, status reads 0, mode reads all ones (edge) and polarity, enable, output data and output enable read 0.
- R2: A write to address 7 drives `pin_oe`, and a write to address 0 drives `pin_out`, from the edge of the write onward. Both registers read back what was written.
- R3: Address 1 returns `pin_in` through two flip-flops: a pin change made between edges is visible after the second rising edge that follows it, and not after the first.
- R4: In edge mode (mode bit 1), a rising pin with polarity 1, or a falling pin with polarity 0, sets that pin's status bit on the third rising edge after the change. The opposite transition sets nothing.
- R5: In level mode (mode bit 0), status is set while the synchronized pin equals its polarity bit. The bit stays set after the level goes away, and a clear does not remove it while the level is still active.
- R6: A status bit is set by its event whatever its enable bit holds.
- R7: Writing address 3 clears exactly the status bits written as 1. Bits written as 0 are unchanged, and address 3 reads as 0.
- R8: `irq_out` is high exactly when some bit is set in both status and enable.
- R9: Writing the polarity register never produces an edge event on a pin whose input is steady.
- R10: When a clear and a new event hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata | output | NUM_PINS | Read data, combinational |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output data to the pads |
| pin_oe | output | NUM_PINS | Output enables to the pads |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench sweeps every pin through all four combinations of mode and polarity. Each pin gets a rise and a fall, with clears in between, and the expected status and interrupt come from an arithmetic model. A detector that swapped polarity or mixed up edge and level would set the wrong bits in this sweep. A detector that failed to latch a level would let a bit drop once the level went away. The bench also flips polarity on a steady high input: a detector that does not refresh its history would raise a false edge there. Finally, it times a clear to land in the same cycle as a fresh edge, which a design where the clear wins would lose, and it writes zeros to the clear register, which a design that ignores the mask would use to wipe status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        REG_DOUT = 3'd0,
        REG_DIN  = 3'd1,
        REG_STAT = 3'd2,
        REG_CLR  = 3'd3,
        REG_IEN  = 3'd4,
        REG_MODE = 3'd5,
        REG_POL  = 3'd6,
        REG_OE   = 3'd7
    } gpio_reg_e;

    localparam int unsigned ADDR_W = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  gpio_reg_e           wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic [NUM_PINS-1:0] dout_q,
    output logic [NUM_PINS-1:0] ien_q,
    output logic [NUM_PINS-1:0] mode_q,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [NUM_PINS-1:0] oe_q,
    output logic [NUM_PINS-1:0] clr_vec,
    output logic                pol_wr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            ien_q  <= '0;
            mode_q <= '1;
            pol_q  <= '0;
            oe_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_DOUT: dout_q <= wr_data;
                REG_IEN:  ien_q  <= wr_data;
                REG_MODE: mode_q <= wr_data;
                REG_POL:  pol_q  <= wr_data;
                REG_OE:   oe_q   <= wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        clr_vec = '0;
        pol_wr  = 1'b0;
        if (wr_en && wr_addr == REG_CLR) clr_vec = wr_data;
        if (wr_en && wr_addr == REG_POL) pol_wr = 1'b1;
    end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    input  logic edge_mode,
    input  logic pol_cur,
    input  logic pol_wr,
    input  logic pol_next,
    output logic evt
);
    logic active;
    logic active_next_pol;
    logic prev_active_q;

    assign active          = pol_cur  ? pin_sync : ~pin_sync;
    assign active_next_pol = pol_next ? pin_sync : ~pin_sync;

    // Reset value matches polarity 0 with a low synchronized input.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      prev_active_q <= 1'b1;
        else if (pol_wr) prev_active_q <= active_next_pol;
        else             prev_active_q <= active;
    end

    assign evt = edge_mode ? (active & ~prev_active_q) : active;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_out
);
    gpio_reg_e           addr_e;
    logic                wr_en;
    logic [NUM_PINS-1:0] dout_q, ien_q, mode_q, pol_q, oe_q;
    logic [NUM_PINS-1:0] clr_vec;
    logic                pol_wr;
    logic [NUM_PINS-1:0] din_sync;
    logic [NUM_PINS-1:0] evt_vec;
    logic [NUM_PINS-1:0] stat_q;

    assign addr_e = gpio_reg_e'(bus_addr);
    assign wr_en  = bus_sel & bus_wr;

    gpio_regs #(.NUM_PINS(NUM_PINS)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr_e),
        .wr_data (bus_wdata),
        .dout_q  (dout_q),
        .ien_q   (ien_q),
        .mode_q  (mode_q),
        .pol_q   (pol_q),
        .oe_q    (oe_q),
        .clr_vec (clr_vec),
        .pol_wr  (pol_wr)
    );

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_d (pin_in),
        .sync_q  (din_sync)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        gpio_detect det_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_sync  (din_sync[g]),
            .edge_mode (mode_q[g]),
            .pol_cur   (pol_q[g]),
            .pol_wr    (pol_wr),
            .pol_next  (bus_wdata[g]),
            .evt       (evt_vec[g])
        );
    end

    // New events take precedence over a clear of the same bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | evt_vec;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (addr_e)
                REG_DOUT: bus_rdata = dout_q;
                REG_DIN:  bus_rdata = din_sync;
                REG_STAT: bus_rdata = stat_q;
                REG_CLR:  bus_rdata = '0;
                REG_IEN:  bus_rdata = ien_q;
                REG_MODE: bus_rdata = mode_q;
                REG_POL:  bus_rdata = pol_q;
                REG_OE:   bus_rdata = oe_q;
            endcase
        end
    end

    assign pin_out = dout_q;
    assign pin_oe  = oe_q;
    assign irq_out = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq_out,
    input logic [NUM_PINS-1:0] stat_q,
    input logic [NUM_PINS-1:0] ien_q,
    input logic [NUM_PINS-1:0] clr_vec,
    input logic [NUM_PINS-1:0] evt_vec
);
    AST_OUT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_DOUT) |=> (pin_out == $past(bus_wdata))); // R2
    AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_OE) |=> (pin_oe == $past(bus_wdata))); // R2
    AST_STAT_HOLDS_UNCLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0)); // R7
    AST_STAT_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat_q & ~$past(stat_q)) & ~$past(evt_vec)) == '0)); // R4
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_vec) & ~stat_q) == '0)); // R10
    AST_IRQ_GATED_BY_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq_out); // R8
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .stat_q    (stat_q),
    .ien_q     (ien_q),
    .clr_vec   (clr_vec),
    .evt_vec   (evt_vec)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    localparam int unsigned NP         = 16;
    localparam time         CLK_PERIOD = 10;

    localparam logic [2:0] A_DOUT = 3'd0, A_DIN = 3'd1, A_STAT = 3'd2, A_CLR = 3'd3;
    localparam logic [2:0] A_IEN  = 3'd4, A_MODE = 3'd5, A_POL = 3'd6, A_OE = 3'd7;
    localparam logic [NP-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq_out;

    int checks = 0;
    int fails  = 0;
    logic [NP-1:0] rv;
    logic [NP-1:0] exp_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.NUM_PINS(NP)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NP-1:0] lvl(input logic [NP-1:0] v, input logic p);
        return p ? v : ~v;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk("R1 pin_out", pin_out, '0);
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 irq_out", {{(NP-1){1'b0}}, irq_out}, '0);
        rd(A_STAT, rv); chk("R1 status", rv, '0);
        rd(A_MODE, rv); chk("R1 mode", rv, ONES);
        rd(A_POL, rv);  chk("R1 polarity", rv, '0);
        rd(A_IEN, rv);  chk("R1 enable", rv, '0);

        // R2 output data and enable
        wr(A_OE, 16'hA5C3);
        chk("R2 pin_oe", pin_oe, 16'hA5C3);
        rd(A_OE, rv); chk("R2 oe readback", rv, 16'hA5C3);
        wr(A_DOUT, 16'h3C96);
        chk("R2 pin_out", pin_out, 16'h3C96);
        rd(A_DOUT, rv); chk("R2 dout readback", rv, 16'h3C96);

        // R3 synchronizer latency
        pin_in = 16'h1234;
        wait_cyc(1);
        rd(A_DIN, rv); chk("R3 din after one edge", rv, '0);
        wait_cyc(1);
        rd(A_DIN, rv); chk("R3 din after two edges", rv, 16'h1234);
        pin_in = '0;
        wait_cyc(4);

        // R4/R5/R6/R8 sweep: every pin, every mode and polarity
        for (int k = 0; k < NP; k++) begin
            for (int m = 0; m < 2; m++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [NP-1:0] bit_k;
                    string tag;
                    bit_k = NP'(1) << k;
                    tag = (m == 1) ? "R4 edge sweep" : "R5 level sweep";
                    pin_in = '0;
                    wr(A_POL, (p == 1) ? ONES : '0);
                    wr(A_MODE, (m == 1) ? ONES : '0);
                    wr(A_IEN, bit_k);
                    wait_cyc(3);
                    wr(A_CLR, ONES);
                    exp_stat = (m == 1) ? '0 : lvl('0, p[0]);
                    rd(A_STAT, rv); chk({tag, " after clear"}, rv, exp_stat);

                    pin_in = bit_k;
                    wait_cyc(3);
                    exp_stat |= (m == 1) ? ((p == 1) ? bit_k : '0) : lvl(bit_k, p[0]);
                    rd(A_STAT, rv); chk({tag, " after rise (R6 unenabled bits)"}, rv, exp_stat);
                    chk("R8 irq after rise", {{(NP-1){1'b0}}, irq_out},
                        {{(NP-1){1'b0}}, |(exp_stat & bit_k)});

                    wr(A_CLR, ONES);
                    exp_stat = (m == 1) ? '0 : lvl(bit_k, p[0]);
                    rd(A_STAT, rv); chk({tag, " clear while high"}, rv, exp_stat);

                    pin_in = '0;
                    wait_cyc(3);
                    exp_stat |= (m == 1) ? ((p == 0) ? bit_k : '0) : lvl('0, p[0]);
                    rd(A_STAT, rv); chk({tag, " after fall"}, rv, exp_stat);
                    chk("R8 irq after fall", {{(NP-1){1'b0}}, irq_out},
                        {{(NP-1){1'b0}}, |(exp_stat & bit_k)});
                end
            end
        end

        // R7 clear mask behaviour
        wr(A_IEN, '0);
        wr(A_POL, ONES);
        wr(A_MODE, ONES);
        wait_cyc(2);
        wr(A_CLR, ONES);
        pin_in = 16'h000F;
        wait_cyc(3);
        rd(A_STAT, rv); chk("R7 setup rise", rv, 16'h000F);
        wr(A_CLR, '0);
        rd(A_STAT, rv); chk("R7 zero clear no effect", rv, 16'h000F);
        wr(A_CLR, 16'h0002);
        rd(A_STAT, rv); chk("R7 single bit clear", rv, 16'h000D);
        rd(A_CLR, rv);  chk("R7 clear reads zero", rv, '0);
        chk("R8 irq with no enables", {{(NP-1){1'b0}}, irq_out}, '0);

        // R9 polarity flips on steady high inputs
        wr(A_POL, '0);
        wait_cyc(2);
        rd(A_STAT, rv); chk("R9 flip to falling", rv, 16'h000D);
        wr(A_CLR, ONES);
        wr(A_POL, ONES);
        wait_cyc(2);
        rd(A_STAT, rv); chk("R9 flip to rising", rv, '0);

        // R10 clear collides with a fresh edge on the same bit
        pin_in = '0;
        wait_cyc(3);
        wr(A_CLR, ONES);
        pin_in = 16'h0001;
        wait_cyc(2);
        wr(A_CLR, 16'h0001);
        rd(A_STAT, rv); chk("R10 event beats clear", rv, 16'h0001);

        finish_run();
    end
endmodule